// File: doc/BRIEF.md
# Descriptor Ring Position Tracker

This block keeps track of the current slot in two circular descriptor rings, one for receive and one for transmit. Each ring has a length register and a position counter. Both values are 16-bit two's-complement numbers. The first slot of a ring is the loaded length value. The position then climbs by one for each descriptor the data path finishes with. A position of zero marks the last slot. The next advance after zero reloads the position from the ring's length register, so the ring starts over at its first slot.

Software reaches all four registers through a small register port. The port works only while the controller is stopped or suspended. At other times, writes are dropped and reads return zero. The initialization sequence loads both length registers through a one-cycle load strobe, and the same strobe sets each position to its first slot. No reset source touches the registers: the hard reset input, the stop flag and the suspend flag all leave them as they are. The data path can use a per-ring last-slot flag and a zero-based slot index without doing any arithmetic of its own.

Top module: `desc_ring_pos`

## Requirements
- R1: When `init_load` is high at a clock edge, both the length register and the position counter of each ring take that ring's load value (`init_rx_len` or `init_tx_len`).
- R2: An advance pulse on a ring whose position is not zero increments the position by one, modulo 2^16. With no advance, no load and no write, the position holds.
- R3: An advance pulse on a ring whose position is zero reloads the position from the value that ring's length register holds at that edge, including a value that software wrote earlier.
- R4: `rx_last` and `tx_last` are high exactly when the ring's position counter equals zero.
- R5: `rx_index` and `tx_index` equal the position minus the length, modulo 2^16.
- R6: While `stop_i` or `suspend_i` is high, a write sets the addressed register and a read returns its value in bits 15:0. The address map is: receive length 0x00, receive position 0x04, transmit length 0x08, transmit position 0x0C.
- R7: While `stop_i` and `suspend_i` are both low, writes change no register and `reg_rdata` reads zero at every address.
- R8: Write data bits 31:16 are dropped and read back as zero. Any address outside the map reads zero, and a write to such an address changes no register.
- R9: When more than one source updates a register at the same edge, the priority is: software write first, then the load strobe, then an advance pulse.
- R10: Holding `rst_n` low and raising or lowering `stop_i` leave all four registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset; does not alter the ring registers |
| stop_i | input | 1 | Controller stopped; enables register access |
| suspend_i | input | 1 | Controller suspended; enables register access |
| init_load | input | 1 | One-cycle strobe that loads both rings |
| init_rx_len | input | 16 | Receive length value (two's complement) used by the load |
| init_tx_len | input | 16 | Transmit length value (two's complement) used by the load |
| rx_adv | input | 1 | One-cycle pulse: receive descriptor consumed |
| tx_adv | input | 1 | One-cycle pulse: transmit descriptor consumed |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| rx_last | output | 1 | Receive position is the last slot |
| tx_last | output | 1 | Transmit position is the last slot |
| rx_index | output | 16 | Zero-based receive slot index |
| tx_index | output | 16 | Zero-based transmit slot index |

## Verification
The advance logic is tested with several pulse patterns. Back-to-back receive pulses cover plain stepping. Pulses every other cycle on the transmit ring show that idle cycles hold the position. A one-slot magnitude makes the ring wrap on almost every pulse. Runs past zero after software has changed the length show whether the reload reads the live register or the load value. Collision cycles put a write and a pulse together, and a load and a pulse together, to show the priority order. Register traffic is sent with the access flags low, during reset and with the upper data bits set, so that dropped writes show up as unchanged readback.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int NRING   = 2;
  localparam int RING_RX = 0;
  localparam int RING_TX = 1;
  localparam int STRIDE  = 8;

  function automatic int len_addr(input int ring);
    return ring * STRIDE;
  endfunction

  function automatic int pos_addr(input int ring);
    return ring * STRIDE + 4;
  endfunction
endpackage

// File: rtl/ring_track.sv
module ring_track #(
  parameter int RING_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_we,
  input  logic              pos_we,
  input  logic [RING_W-1:0] wdata,
  input  logic              init_ld,
  input  logic [RING_W-1:0] init_val,
  input  logic              adv,
  output logic [RING_W-1:0] len_q,
  output logic [RING_W-1:0] pos_q,
  output logic              is_last,
  output logic [RING_W-1:0] index
);
  logic [RING_W-1:0] len_d, pos_d;
  logic              len_en, pos_en;

  // next-state: software write beats load, load beats advance
  always_comb begin
    len_en = len_we | init_ld;
    len_d  = len_we ? wdata : init_val;
    pos_en = pos_we | init_ld | adv;
    if (pos_we)                pos_d = wdata;
    else if (init_ld)          pos_d = init_val;
    else if (pos_q == '0)      pos_d = len_q;
    else                       pos_d = pos_q + 1'b1;
  end

  // no reset: contents survive every reset source
  always_ff @(posedge clk) begin
    if (len_en) len_q <= len_d;
  end

  always_ff @(posedge clk) begin
    if (pos_en) pos_q <= pos_d;
  end

  assign is_last = (pos_q == '0);
  assign index   = pos_q - len_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !pos_we && !init_ld && pos_q != '0 |=> pos_q == $past(pos_q) + 1'b1);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !pos_we && !init_ld |=> $stable(pos_q));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !pos_we && !init_ld && pos_q == '0 |=> pos_q == $past(len_q));
  p_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_ld && !pos_we |=> pos_q == $past(init_val));
  p_swwin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pos_we |=> pos_q == $past(wdata));
endmodule

// File: rtl/ring_regif.sv
module ring_regif
  import ring_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RING_W = 16
) (
  input  logic                          stop_i,
  input  logic                          suspend_i,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          we,
  input  logic [NRING-1:0][RING_W-1:0]  len_q,
  input  logic [NRING-1:0][RING_W-1:0]  pos_q,
  output logic [NRING-1:0]              len_we,
  output logic [NRING-1:0]              pos_we,
  output logic [DATA_W-1:0]             rdata
);
  logic access;
  assign access = stop_i | suspend_i;

  for (genvar r = 0; r < NRING; r++) begin : g_dec
    assign len_we[r] = access && we && (addr == ADDR_W'(len_addr(r)));
    assign pos_we[r] = access && we && (addr == ADDR_W'(pos_addr(r)));
  end

  always_comb begin
    rdata = '0;
    if (access) begin
      for (int r = 0; r < NRING; r++) begin
        if (addr == ADDR_W'(len_addr(r))) rdata[RING_W-1:0] = len_q[r];
        if (addr == ADDR_W'(pos_addr(r))) rdata[RING_W-1:0] = pos_q[r];
      end
    end
  end
endmodule

// File: rtl/desc_ring_pos.sv
module desc_ring_pos
  import ring_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RING_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              suspend_i,
  input  logic              init_load,
  input  logic [RING_W-1:0] init_rx_len,
  input  logic [RING_W-1:0] init_tx_len,
  input  logic              rx_adv,
  input  logic              tx_adv,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rx_last,
  output logic              tx_last,
  output logic [RING_W-1:0] rx_index,
  output logic [RING_W-1:0] tx_index
);
  logic [NRING-1:0][RING_W-1:0] len_q, pos_q, index, init_v;
  logic [NRING-1:0]             len_we, pos_we, adv, last;

  assign init_v[RING_RX] = init_rx_len;
  assign init_v[RING_TX] = init_tx_len;
  assign adv[RING_RX]    = rx_adv;
  assign adv[RING_TX]    = tx_adv;

  ring_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RING_W(RING_W)) u_regif (
    .stop_i(stop_i), .suspend_i(suspend_i), .addr(reg_addr), .we(reg_we),
    .len_q(len_q), .pos_q(pos_q), .len_we(len_we), .pos_we(pos_we),
    .rdata(reg_rdata)
  );

  for (genvar r = 0; r < NRING; r++) begin : g_ring
    ring_track #(.RING_W(RING_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .len_we(len_we[r]), .pos_we(pos_we[r]),
      .wdata(reg_wdata[RING_W-1:0]), .init_ld(init_load), .init_val(init_v[r]),
      .adv(adv[r]), .len_q(len_q[r]), .pos_q(pos_q[r]), .is_last(last[r]),
      .index(index[r])
    );
  end

  assign rx_last  = last[RING_RX];
  assign tx_last  = last[RING_TX];
  assign rx_index = index[RING_RX];
  assign tx_index = index[RING_TX];

  p_we_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_i | suspend_i) |-> (len_we == '0 && pos_we == '0));
  p_rd_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_i | suspend_i) |-> reg_rdata == '0);
  p_one_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({len_we, pos_we}));
  p_hi_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:RING_W] == '0);
  p_len_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !init_load && !reg_we |=> $stable(len_q));
endmodule

// File: tb/tb_desc_ring_pos.sv
`timescale 1ns/1ps
module tb_desc_ring_pos;
  logic        clk = 1'b0;
  logic        rst_n, stop_i, suspend_i, init_load, rx_adv, tx_adv, reg_we;
  logic [15:0] init_rx_len, init_tx_len, rx_index, tx_index;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rx_last, tx_last;

  always #2.5 clk = ~clk;

  desc_ring_pos dut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .suspend_i(suspend_i),
    .init_load(init_load), .init_rx_len(init_rx_len), .init_tx_len(init_tx_len),
    .rx_adv(rx_adv), .tx_adv(tx_adv), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_last(rx_last),
    .tx_last(tx_last), .rx_index(rx_index), .tx_index(tx_index)
  );

  int    total = 0, bad = 0;
  bit    done = 0, known = 0;
  string cur = "R7";
  bit [15:0] mlen [2];
  bit [15:0] mpos [2];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] model_read();
    if (!(stop_i | suspend_i)) return 32'h0;
    case (reg_addr)
      8'h00: return {16'h0, mlen[0]};
      8'h04: return {16'h0, mpos[0]};
      8'h08: return {16'h0, mlen[1]};
      8'h0C: return {16'h0, mpos[1]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_update();
    bit acc = stop_i | suspend_i;
    for (int r = 0; r < 2; r++) begin
      bit [15:0] nl = mlen[r];
      bit [15:0] np = mpos[r];
      bit a = (r == 0) ? rx_adv : tx_adv;
      if (a) np = (mpos[r] == 16'h0) ? mlen[r] : mpos[r] + 16'h1;
      if (init_load) begin
        nl = (r == 0) ? init_rx_len : init_tx_len;
        np = nl;
      end
      if (acc && reg_we && reg_addr == 8'(r * 8))     nl = reg_wdata[15:0];
      if (acc && reg_we && reg_addr == 8'(r * 8 + 4)) np = reg_wdata[15:0];
      mlen[r] = nl;
      mpos[r] = np;
    end
    if (init_load) known = 1;
  endtask

  task automatic cyc();
    #1;
    if (known || !(stop_i | suspend_i)) chk({cur, " rdata"}, reg_rdata, model_read());
    @(posedge clk);
    model_update();
    @(negedge clk);
    if (known) begin
      chk("R4 rx_last", {31'h0, rx_last}, {31'h0, mpos[0] == 16'h0});
      chk("R4 tx_last", {31'h0, tx_last}, {31'h0, mpos[1] == 16'h0});
      chk({cur, " R5 rx_index"}, {16'h0, rx_index}, {16'h0, mpos[0] - mlen[0]});
      chk({cur, " R5 tx_index"}, {16'h0, tx_index}, {16'h0, mpos[1] - mlen[1]});
    end
    init_load = 0; rx_adv = 0; tx_adv = 0; reg_we = 0;
  endtask

  task automatic rd_all();
    for (int a = 0; a < 4; a++) begin
      reg_addr = 8'(a * 4);
      cyc();
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_we = 1; reg_wdata = d;
    cyc();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; stop_i = 0; suspend_i = 0; init_load = 0; rx_adv = 0; tx_adv = 0;
    reg_we = 0; reg_addr = 8'h00; reg_wdata = 32'h0;
    init_rx_len = 16'hFFFC; init_tx_len = 16'hFFFF;
    @(negedge clk);
    // reset state: access flags low, reads zero (R7)
    cur = "R7"; cyc();
    // R1: load strobe
    cur = "R1"; init_load = 1; cyc();
    stop_i = 1; rd_all();
    // R2 / R3 patterns: back-to-back rx, every-other tx (one-slot magnitude)
    stop_i = 0; rst_n = 1; cur = "R2";
    for (int i = 0; i < 9; i++) begin
      rx_adv = 1; tx_adv = (i % 2 == 0); cyc();
    end
    // R7: writes with no access flag are dropped
    cur = "R7";
    wr(8'h00, 32'h0000_1234); wr(8'h0C, 32'h0000_0042);
    stop_i = 1; cur = "R7"; rd_all(); stop_i = 0;
    // R6 / R8: access through suspend, upper bits and unmapped addresses
    suspend_i = 1; cur = "R6";
    wr(8'h00, 32'hABCD_FFFE); wr(8'h0C, 32'h5555_FFF0);
    cur = "R8"; rd_all();
    wr(8'h20, 32'h0000_0001); wr(8'h02, 32'h0000_0003);
    reg_addr = 8'h20; cyc(); reg_addr = 8'h02; cyc(); reg_addr = 8'hFF; cyc();
    rd_all();
    // R3: wrap uses the rewritten length
    suspend_i = 0; cur = "R3";
    for (int i = 0; i < 12; i++) begin
      rx_adv = 1; tx_adv = 1; cyc();
    end
    // R9: write beats advance, load beats advance
    suspend_i = 1; cur = "R9";
    reg_addr = 8'h0C; reg_we = 1; reg_wdata = 32'h0000_0007; tx_adv = 1; cyc();
    init_rx_len = 16'hFFF8; init_tx_len = 16'hFFFD; init_load = 1; rx_adv = 1; cyc();
    reg_addr = 8'h00; reg_we = 1; reg_wdata = 32'h0000_FFF0; init_load = 1; cyc();
    rd_all();
    suspend_i = 0;
    rx_adv = 1; cyc(); tx_adv = 1; cyc();
    // R10: hard reset and stop toggling leave registers alone
    cur = "R10"; rst_n = 0;
    for (int i = 0; i < 4; i++) begin
      stop_i = (i % 2 == 0); cyc();
    end
    rst_n = 1; stop_i = 1; rd_all();
    stop_i = 0; cyc(); stop_i = 1; rd_all();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule